// File: doc/BRIEF.md
# Motor Controller Enable, Sleep and Reset Sequencer

This block is the power and reset sequencer of a brushless motor controller. It watches an enable pin whose active level is chosen by a polarity bit, an active-high reset pin and a tachometer pulse from the motor. From these inputs it decides when the motor drive may run and when the drive must be stopped. After a stop it decides whether the internal regulator, the power switch and the core clocks are shut off, or whether the register file is reloaded from nonvolatile storage.

A stop begins when a disable request has been filtered long enough to count, when the polarity bit changes, or when reset is asserted while the motor runs. A stop turns the drive off. The brake-mode bit picks braking or coasting. The block then waits until the tachometer has been quiet for the full stop window. After a disable it drops into sleep, with the regulator and clocks off. After a reset it asks the surrounding logic for a register reload and a fault clear, then holds the drive off until reset goes away. Once a stop has started, it always runs to its end. A reset seen during a disable-driven stop or during sleep is remembered and serviced at the next wake.

States: SLEEP (regulator and clocks off), RUN (drive on), STOP (drive off, braking or coasting, waiting for a quiet tachometer), RELOAD (reload request out, fault-clear pulse on entry), HOLD (reload done, drive off while reset is high). Transitions:
- SLEEP→RUN: wake with no reset pending.
- SLEEP→RELOAD: wake with a reset pending.
- RUN→STOP: reset, a qualified disable, or a polarity change.
- STOP→SLEEP: quiet window expired after a disable.
- STOP→RELOAD: quiet window expired after a reset.
- RELOAD→HOLD: acknowledge.
- HOLD→RUN: reset released.

Top module: `motor_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and after it until the first wake, every output is 0. The power-on state counts as a pending reset, so the first wake enters RELOAD: `reload_req`=1, `reg_on`=1, `clk_on`=1, `drive_on`=0.
- R2: `reload_req` stays 1 until a cycle with `reload_ack`=1. `fault_clr` is 1 for exactly one cycle, the first cycle of `reload_req`.
- R3: After the reload acknowledge, `drive_on` stays 0 while the reset pin is 1 and becomes 1 within 6 cycles of the reset pin going to 0.
- R4: The enable pin is inactive when `en_pin` differs from the active level: active level is 1 when `en_active_low`=0 and 0 when it is 1. An inactive enable lasting at most QUAL-2 cycles does not turn the drive off. QUAL is the clock frequency times QUAL_TIME_NS, rounded down.
- R5: An inactive enable lasting QUAL+6 cycles turns `drive_on` off. While the drive is off during a stop, `brake_on` equals `brake_sel`: 1 means brake, 0 means coast. `brake_on` is 0 whenever `drive_on` is 1.
- R6: After a disable stop, `reg_on` and `clk_on` stay 1 until `tach_in` has shown no edge for the stop window (clock frequency times STOP_TIME_MS). Every tachometer edge restarts the window. After the window both go to 0, and only after the drive was already off.
- R7: A stop that has started finishes even if enable returns to active. If enable is active when sleep is reached, the drive restarts without a reload.
- R8: A change of `en_active_low` while running starts a stop.
- R9: A reset pin pulse during a disable stop is remembered. The next wake issues a reload before the drive runs.
- R10: The reset pin while running stops the drive. `reg_on` stays 1 through the stop, and a reload is issued once the quiet window expires.
- R11: With `en_active_low`=1 and `en_pin` tied to `rst_pin`, both pins at 1 stop the drive and cause a reload and fault clear. Both pins at 0 start the drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| en_pin | input | 1 | Enable pin, asynchronous |
| rst_pin | input | 1 | Reset pin, active high, asynchronous |
| en_active_low | input | 1 | Enable polarity select, 1 = active low |
| brake_sel | input | 1 | Stop mode, 1 = brake, 0 = coast |
| tach_in | input | 1 | Tachometer feedback, asynchronous |
| reload_ack | input | 1 | Register reload finished |
| drive_on | output | 1 | Motor drive enable |
| brake_on | output | 1 | Brake the motor while the drive is off |
| reg_on | output | 1 | Regulator and power switch enable |
| clk_on | output | 1 | Internal clock enable |
| reload_req | output | 1 | Register reload request, held to acknowledge |
| fault_clr | output | 1 | Single-cycle fault clear strobe |

## Verification
The bench builds the block with CLK_FREQ_HZ = 1,000,000, QUAL_TIME_NS = 8,000 and STOP_TIME_MS = 1. This gives an 8-cycle qualification filter and a 1000-cycle quiet window. With these values a dozen complete stop, sleep and reload sequences fit in a short run, including tachometer edges that restart the window near its end. The short filter also lets random enable glitches probe both sides of the qualification boundary.

// File: rtl/motor_pwr_seq_pkg.sv
package motor_pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP  = 3'd0,
        ST_RUN    = 3'd1,
        ST_STOP   = 3'd2,
        ST_RELOAD = 3'd3,
        ST_HOLD   = 3'd4
    } seq_state_t;

    localparam int unsigned SYNC_W = 3;

endpackage

// File: rtl/mps_sync.sv
module mps_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/mps_qual.sv
module mps_qual #(
    parameter int unsigned LIMIT = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic qualified
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (active) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qualified = (cnt == LIM);
endmodule

// File: rtl/mps_quiet.sv
module mps_quiet #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic tach,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;
    logic          tach_q;
    logic          tach_edge;

    assign tach_edge = tach ^ tach_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tach_q <= 1'b0;
            cnt    <= '0;
        end else begin
            tach_q <= tach;
            if (!arm || tach_edge) begin
                cnt <= '0;
            end else if (cnt != LIM) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign expired = arm && (cnt == LIM);
endmodule

// File: rtl/motor_pwr_seq.sv
module motor_pwr_seq
    import motor_pwr_seq_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ  = 50_000_000,
    parameter int unsigned QUAL_TIME_NS = 1200,
    parameter int unsigned STOP_TIME_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_pin,
    input  logic rst_pin,
    input  logic en_active_low,
    input  logic brake_sel,
    input  logic tach_in,
    input  logic reload_ack,
    output logic drive_on,
    output logic brake_on,
    output logic reg_on,
    output logic clk_on,
    output logic reload_req,
    output logic fault_clr
);
    localparam longint unsigned QUAL_RAW =
        (64'(CLK_FREQ_HZ) * 64'(QUAL_TIME_NS)) / 64'd1_000_000_000;
    localparam longint unsigned STOP_RAW =
        (64'(CLK_FREQ_HZ) * 64'(STOP_TIME_MS)) / 64'd1_000;
    localparam int unsigned QUAL_CYC = (QUAL_RAW < 64'd1) ? 1 : 32'(QUAL_RAW);
    localparam int unsigned STOP_CYC = (STOP_RAW < 64'd1) ? 1 : 32'(STOP_RAW);

    // synchronized pins: [0] enable, [1] reset, [2] tachometer
    logic [SYNC_W-1:0] pins_s;
    logic en_s, rst_s, tach_s;

    mps_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({tach_in, rst_pin, en_pin}),
        .q     (pins_s)
    );

    assign en_s   = pins_s[0];
    assign rst_s  = pins_s[1];
    assign tach_s = pins_s[2];

    logic en_act;
    assign en_act = en_s ^ en_active_low;

    logic dis_qual;
    mps_qual #(.LIMIT(QUAL_CYC)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (en_act),
        .qualified (dis_qual)
    );

    seq_state_t state, state_nx;

    logic quiet_done;
    mps_quiet #(.LIMIT(STOP_CYC)) u_quiet (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (state == ST_STOP),
        .tach    (tach_s),
        .expired (quiet_done)
    );

    logic pol_q;
    logic pol_chg;
    logic rst_pend;
    logic cause_rst;
    logic rl_seen;

    assign pol_chg = (pol_q != en_active_low);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SLEEP: begin
                if (en_act) begin
                    state_nx = (rst_pend || rst_s) ? ST_RELOAD : ST_RUN;
                end
            end
            ST_RUN: begin
                if (rst_s || dis_qual || pol_chg) begin
                    state_nx = ST_STOP;
                end
            end
            ST_STOP: begin
                if (quiet_done) begin
                    state_nx = cause_rst ? ST_RELOAD : ST_SLEEP;
                end
            end
            ST_RELOAD: begin
                if (reload_ack) begin
                    state_nx = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!rst_s) begin
                    state_nx = ST_RUN;
                end
            end
            default: state_nx = ST_SLEEP;
        endcase
    end

    // state register and sequencing flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_SLEEP;
            pol_q     <= 1'b0;
            rst_pend  <= 1'b1;
            cause_rst <= 1'b0;
            rl_seen   <= 1'b0;
        end else begin
            state   <= state_nx;
            pol_q   <= en_active_low;
            rl_seen <= (state == ST_RELOAD);
            if (state == ST_RUN && state_nx == ST_STOP) begin
                cause_rst <= rst_s;
            end else if (state_nx == ST_RUN) begin
                cause_rst <= 1'b0;
            end
            if (state_nx == ST_RELOAD) begin
                rst_pend <= 1'b0;
            end else if (rst_s && (state == ST_SLEEP || state == ST_STOP)) begin
                rst_pend <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        drive_on   = 1'b0;
        brake_on   = 1'b0;
        reg_on     = 1'b1;
        clk_on     = 1'b1;
        reload_req = 1'b0;
        fault_clr  = 1'b0;
        unique case (state)
            ST_SLEEP: begin
                reg_on = 1'b0;
                clk_on = 1'b0;
            end
            ST_RUN: begin
                drive_on = 1'b1;
            end
            ST_STOP: begin
                brake_on = brake_sel;
            end
            ST_RELOAD: begin
                reload_req = 1'b1;
                fault_clr  = !rl_seen;
            end
            ST_HOLD: begin
                drive_on = 1'b0;
            end
            default: begin
                reg_on = 1'b0;
                clk_on = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/motor_pwr_seq_chk.sv
module motor_pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic reload_ack,
    input logic drive_on,
    input logic brake_on,
    input logic reg_on,
    input logic clk_on,
    input logic reload_req,
    input logic fault_clr
);
    p_unpowered_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_on |-> (!drive_on && !clk_on && !reload_req));

    p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_req && !reload_ack) |=> reload_req);

    p_clr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |=> !fault_clr);

    p_clr_with_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |-> reload_req);

    p_no_brake_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drive_on |-> !brake_on);

    p_power_after_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_on) |-> !$past(drive_on));
endmodule

bind motor_pwr_seq motor_pwr_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload_ack (reload_ack),
    .drive_on   (drive_on),
    .brake_on   (brake_on),
    .reg_on     (reg_on),
    .clk_on     (clk_on),
    .reload_req (reload_req),
    .fault_clr  (fault_clr)
);

// File: tb/test_motor_pwr_seq.sv
module test_motor_pwr_seq;
    localparam int unsigned F_HZ = 1_000_000;
    localparam int unsigned Q_NS = 8000;
    localparam int unsigned S_MS = 1;
    localparam int QUAL = 8;
    localparam int STOP = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_pin = 1'b0, rst_pin = 1'b0, en_active_low = 1'b0;
    logic brake_sel = 1'b0, tach_in = 1'b0, reload_ack = 1'b0;
    logic drive_on, brake_on, reg_on, clk_on, reload_req, fault_clr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit saw_reload = 0;
    bit saw_regoff = 0;

    always #5 clk = ~clk;

    motor_pwr_seq #(.CLK_FREQ_HZ(F_HZ), .QUAL_TIME_NS(Q_NS), .STOP_TIME_MS(S_MS)) i_motor_pwr_seq (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .rst_pin(rst_pin),
        .en_active_low(en_active_low), .brake_sel(brake_sel), .tach_in(tach_in),
        .reload_ack(reload_ack), .drive_on(drive_on), .brake_on(brake_on),
        .reg_on(reg_on), .clk_on(clk_on), .reload_req(reload_req), .fault_clr(fault_clr)
    );

    always @(negedge clk) begin
        if (reload_req) saw_reload = 1;
        if (rst_n && !reg_on) saw_regoff = 1;
    end

    function automatic bit exp_brake(input bit sel);
        return sel;
    endfunction

    function automatic bit active_level(input bit pol);
        return !pol;
    endfunction

    function automatic int qual_limit();
        return QUAL + 6;
    endfunction

    function automatic int stop_limit();
        return STOP + 20;
    endfunction

    function automatic bit cur(input int sel);
        case (sel)
            0: return drive_on;
            1: return reg_on;
            2: return reload_req;
            default: return clk_on;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_for(input int sel, input bit val, input int maxc, output bit ok);
        ok = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (cur(sel) == val) begin
                ok = 1;
                return;
            end
        end
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        reload_ack = 1;
        @(negedge clk);
        reload_ack = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_bad++;
                $display("FAIL watchdog expired before end of sequence (all R)");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        bit ok;
        bit bsel;
        void'($urandom(32'd1234));

        // R1: reset state
        idle(4);
        chk("R1 outputs in reset", {drive_on, brake_on, reg_on, clk_on, reload_req, fault_clr}, 0);
        @(negedge clk) rst_n = 1;
        idle(10);
        chk("R1 asleep until wake", {drive_on, reg_on, clk_on, reload_req}, 0);

        // R1/R2: first wake reloads
        en_pin = active_level(en_active_low);
        wait_for(2, 1, 10, ok);
        chk("R1 wake issues reload", ok, 1);
        chk("R1 powered during reload", {reg_on, clk_on, drive_on}, 3'b110);
        chk("R2 fault clear on first reload cycle", fault_clr, 1);
        idle(1);
        chk("R2 fault clear single cycle", fault_clr, 0);
        idle(5);
        chk("R2 request held without ack", reload_req, 1);
        ack_pulse();
        wait_for(0, 1, 6, ok);
        chk("R3 drive starts after ack", ok, 1);
        chk("R2 request dropped after ack", reload_req, 0);

        // R4: random short glitches ignored
        for (int k = 0; k < 8; k++) begin
            int len = 1 + int'($urandom % (QUAL - 2));
            en_pin = !active_level(en_active_low);
            idle(len);
            en_pin = active_level(en_active_low);
            idle(15);
            chk("R4 short inactive enable ignored", drive_on, 1);
        end

        // R5/R6: qualified disable, brake mode, tach restarts window
        bsel = 1'($urandom);
        brake_sel = bsel;
        en_pin = !active_level(en_active_low);
        wait_for(0, 0, qual_limit(), ok);
        chk("R5 qualified disable stops drive", ok, 1);
        idle(2);
        chk("R5 brake output follows mode bit", brake_on, exp_brake(bsel));
        brake_sel = !bsel;
        idle(2);
        chk("R5 coast/brake follows mode bit", brake_on, exp_brake(!bsel));
        for (int k = 0; k < 3; k++) begin
            idle(200 + int'($urandom % 300));
            tach_in = !tach_in;
        end
        idle(STOP - 50);
        chk("R6 regulator held while window restarted by tach", {reg_on, clk_on}, 2'b11);
        wait_for(1, 0, 100, ok);
        chk("R6 regulator off after quiet window", ok, 1);
        chk("R6 clocks off after quiet window", clk_on, 0);

        // wake with no pending reset: no reload
        saw_reload = 0;
        en_pin = active_level(en_active_low);
        wait_for(0, 1, 10, ok);
        chk("R7 wake without pending reset runs", ok, 1);

        // R7: shutdown continues when enable returns
        en_pin = !active_level(en_active_low);
        idle(QUAL + 5);
        en_pin = active_level(en_active_low);
        idle(500);
        chk("R7 stop continues after enable returns", {drive_on, reg_on}, 2'b01);
        wait_for(0, 1, stop_limit(), ok);
        chk("R7 restart after stopped period", ok, 1);
        chk("R7 restart without reload", saw_reload, 0);

        // R9: reset during a disable stop is remembered
        en_pin = !active_level(en_active_low);
        wait_for(0, 0, qual_limit(), ok);
        idle(100);
        rst_pin = 1;
        idle(4);
        rst_pin = 0;
        wait_for(1, 0, stop_limit(), ok);
        chk("R9 sleep reached", ok, 1);
        en_pin = active_level(en_active_low);
        wait_for(2, 1, 10, ok);
        chk("R9 pending reset serviced on wake", ok, 1);
        ack_pulse();
        wait_for(0, 1, 6, ok);
        chk("R9 drive after serviced reset", ok, 1);

        // R8: polarity change starts a stop
        saw_reload = 0;
        en_active_low = 1;
        en_pin = active_level(1);
        wait_for(0, 0, 6, ok);
        chk("R8 polarity change stops drive", ok, 1);
        wait_for(0, 1, stop_limit() + 10, ok);
        chk("R8 restart with new polarity", ok, 1);
        chk("R8 no reload after polarity stop", saw_reload, 0);

        // R10: reset while running
        saw_regoff = 0;
        rst_pin = 1;
        wait_for(0, 0, 6, ok);
        chk("R10 reset stops drive", ok, 1);
        wait_for(2, 1, stop_limit(), ok);
        chk("R10 reload after quiet window", ok, 1);
        chk("R10 regulator stays on", saw_regoff, 0);
        ack_pulse();
        idle(20);
        chk("R3 drive held off while reset high", drive_on, 0);
        rst_pin = 0;
        wait_for(0, 1, 6, ok);
        chk("R3 drive on after reset release", ok, 1);

        // R11: tied pins, active-low enable
        saw_regoff = 0;
        en_pin = 1;
        rst_pin = 1;
        wait_for(0, 0, 6, ok);
        chk("R11 both high stops drive", ok, 1);
        wait_for(2, 1, stop_limit(), ok);
        chk("R11 both high reloads", ok, 1);
        chk("R11 fault clear with reload", fault_clr, 1);
        ack_pulse();
        idle(10);
        chk("R11 drive off while pins high", drive_on, 0);
        en_pin = 0;
        rst_pin = 0;
        wait_for(0, 1, 6, ok);
        chk("R11 both low starts drive", ok, 1);
        chk("R11 regulator never dropped", saw_regoff, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule